// File: doc/BRIEF.md
# Indexed Prefix Address Generator

This block sits in the byte-stream decoder of an 8-bit processor and handles instructions that start with an index prefix. It watches a stream of fetched bytes qualified by a valid strobe. A prefix byte picks one of two 16-bit index registers, whose current values arrive on dedicated inputs. The block collects the opcode that follows and any displacement, immediate byte or 16-bit immediate word. It then forms the effective address as the chosen index plus the sign-extended displacement. Finally it hands a one-cycle result to a downstream sequencer: the instruction class, the register field, any immediate, the cycle count and the program-counter advance.

The controller has six named states. `ST_IDLE` waits for a prefix. `ST_OPCODE` waits for the opcode byte. `ST_DISP` takes the displacement. `ST_IMM8` takes the immediate byte of the immediate store. `ST_WLO` and `ST_WHI` take the two halves of the 16-bit immediate word. The transitions are as follows:
- *arm*: ST_IDLE to ST_OPCODE on a prefix byte.
- *rearm*: ST_OPCODE to itself on another prefix byte.
- *finish-short*: ST_OPCODE to ST_IDLE for forms with no operand bytes.
- *to-disp*: ST_OPCODE to ST_DISP.
- *to-word*: ST_OPCODE to ST_WLO.
- *finish-disp*: ST_DISP to ST_IDLE.
- *to-imm*: ST_DISP to ST_IMM8.
- *finish-imm*: ST_IMM8 to ST_IDLE.
- *word-lo*: ST_WLO to ST_WHI.
- *finish-word*: ST_WHI to ST_IDLE.

A state moves only on a cycle where the valid strobe is high. Memory access and all arithmetic apart from the address sum belong to other blocks.

Top module: `idx_prefix_agu`

## Requirements
- R1: After reset, `done` is 0, all result outputs are 0 and the block waits for a prefix.
- R2: Prefix byte 0xDD selects the first index (`sel_iy`=0) and 0xFD selects the second (`sel_iy`=1). While the block waits for a prefix, any other valid byte is ignored and produces no result.
- R3: For displacement forms, `ea` is the selected index plus the sign-extended displacement byte, taken modulo 65536. For all other forms `ea` is 0.
- R4: Opcodes 0x46, 0x4E, 0x56, 0x5E, 0x66, 0x6E and 0x7E are followed by one displacement byte. They give class 1 (indexed load), `reg_code` = opcode bits 5:3, 19 cycles and a PC advance of 3.
- R5: Opcodes 0x70–0x75 and 0x77 are followed by one displacement byte. They give class 2 (indexed store), `reg_code` = opcode bits 2:0, 19 cycles and a PC advance of 3.
- R6: Opcode 0x36 is followed by a displacement byte and then an immediate byte n. It gives class 3, `imm_word` = {0x00, n}, 19 cycles and a PC advance of 4.
- R7: Opcode 0x21 is followed by a low byte and then a high byte. It gives class 4, `imm_word` = {high, low}, 14 cycles and a PC advance of 4.
- R8: Opcode 0xE5 gives class 5 (push index) with 15 cycles. Opcode 0xE1 gives class 6 (pop index) with 14 cycles. Both take no operand bytes and give a PC advance of 2.
- R9: Opcode 0xB6 is followed by one displacement byte. It gives class 7 (OR accumulator with the indexed byte), 19 cycles and a PC advance of 3.
- R10: Any other opcode ends the instruction at once with class 8 (unsupported), 8 cycles, a PC advance of 2 and no operand bytes consumed.
- R11: A prefix byte that arrives while the block waits for an opcode replaces the earlier selection. The last prefix wins.
- R12: Cycles without a valid byte change no state, and bytes presented on those cycles are ignored.
- R13: `done` is high for exactly one cycle, in the cycle after the last byte of the instruction is accepted. The result outputs hold their values until the next `done`. Fields an instruction does not use (`reg_code`, `imm_word`) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Byte strobe for `byte_in` |
| byte_in | input | 8 | Fetched instruction byte |
| ix_val | input | 16 | Current value of the first index register |
| iy_val | input | 16 | Current value of the second index register |
| done | output | 1 | One-cycle result strobe |
| sel_iy | output | 1 | Index used: 0 first, 1 second |
| cls | output | 4 | Instruction class code |
| reg_code | output | 3 | Register field taken from the opcode |
| ea | output | 16 | Effective address |
| imm_word | output | 16 | Immediate byte or word |
| cycles | output | 5 | Reported cycle count |
| pc_adv | output | 3 | Program-counter advance in bytes |

## Verification
The hardest situation to reach from the ports is a prefix arriving while the block already holds a prefix and waits for an opcode. Random streams would almost never form it on their own. Directed sequences send two different prefixes back to back, with and without idle gaps between them, before a displacement load, and then check which index fed the address. Address wrap in both directions is driven directly: an index near the top of the space with a positive displacement, and one near zero with a negative displacement. The random part inserts idle gaps carrying garbage bytes between every pair of accepted bytes.

// File: rtl/agu_pkg.sv
package agu_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 16;
    localparam int unsigned CLS_W  = 4;
    localparam int unsigned CYC_W  = 5;
    localparam int unsigned ADV_W  = 3;

    localparam logic [BYTE_W-1:0] PFX_FIRST  = 8'hDD;
    localparam logic [BYTE_W-1:0] PFX_SECOND = 8'hFD;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_DISP,
        ST_IMM8,
        ST_WLO,
        ST_WHI
    } seq_state_t;

    typedef enum logic [CLS_W-1:0] {
        CLS_NONE   = 4'd0,
        CLS_LOAD   = 4'd1,
        CLS_STORE  = 4'd2,
        CLS_STIMM  = 4'd3,
        CLS_LDWORD = 4'd4,
        CLS_PUSH   = 4'd5,
        CLS_POP    = 4'd6,
        CLS_ORMEM  = 4'd7,
        CLS_UNSUP  = 4'd8
    } op_cls_t;

    typedef struct packed {
        op_cls_t          cls;
        logic [CYC_W-1:0] cyc;
        logic [ADV_W-1:0] adv;
        logic [2:0]       rcode;
        logic             need_disp;
        logic             need_imm8;
        logic             need_word;
    } op_info_t;

endpackage

// File: rtl/agu_opdec.sv
module agu_opdec
    import agu_pkg::*;
(
    input  logic [BYTE_W-1:0] opc,
    output op_info_t          info
);

    logic is_load;
    logic is_store;

    // register loads: 01 rrr 110, target field must not be the memory code
    assign is_load  = (opc[7:6] == 2'b01) && (opc[2:0] == 3'b110) && (opc[5:3] != 3'b110);
    // register stores: 01110 sss, source field must not be the memory code
    assign is_store = (opc[7:3] == 5'b01110) && (opc[2:0] != 3'b110);

    always_comb begin
        info           = '0;
        info.cls       = CLS_UNSUP;
        info.cyc       = CYC_W'(8);
        info.adv       = ADV_W'(2);
        if (is_load) begin
            info.cls       = CLS_LOAD;
            info.cyc       = CYC_W'(19);
            info.adv       = ADV_W'(3);
            info.rcode     = opc[5:3];
            info.need_disp = 1'b1;
        end else if (is_store) begin
            info.cls       = CLS_STORE;
            info.cyc       = CYC_W'(19);
            info.adv       = ADV_W'(3);
            info.rcode     = opc[2:0];
            info.need_disp = 1'b1;
        end else begin
            unique case (opc)
                8'h36: begin
                    info.cls       = CLS_STIMM;
                    info.cyc       = CYC_W'(19);
                    info.adv       = ADV_W'(4);
                    info.need_disp = 1'b1;
                    info.need_imm8 = 1'b1;
                end
                8'h21: begin
                    info.cls       = CLS_LDWORD;
                    info.cyc       = CYC_W'(14);
                    info.adv       = ADV_W'(4);
                    info.need_word = 1'b1;
                end
                8'hE5: begin
                    info.cls = CLS_PUSH;
                    info.cyc = CYC_W'(15);
                    info.adv = ADV_W'(2);
                end
                8'hE1: begin
                    info.cls = CLS_POP;
                    info.cyc = CYC_W'(14);
                    info.adv = ADV_W'(2);
                end
                8'hB6: begin
                    info.cls       = CLS_ORMEM;
                    info.cyc       = CYC_W'(19);
                    info.adv       = ADV_W'(3);
                    info.need_disp = 1'b1;
                end
                default: begin
                    info.cls = CLS_UNSUP;
                end
            endcase
        end
    end

endmodule

// File: rtl/agu_ea.sv
module agu_ea #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic [AW-1:0] idx_a,
    input  logic [AW-1:0] idx_b,
    input  logic          pick_b,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] addr
);

    localparam int unsigned EXT_W = AW - DW;

    logic [AW-1:0] base;
    logic [AW-1:0] offs;

    assign base = pick_b ? idx_b : idx_a;

    generate
        if (EXT_W > 0) begin : g_ext
            assign offs = {{EXT_W{disp[DW-1]}}, disp};
        end else begin : g_noext
            assign offs = disp[AW-1:0];
        end
    endgenerate

    // full-width sum, carry out discarded: wraps modulo 2**AW
    assign addr = base + offs;

endmodule

// File: rtl/agu_seq.sv
module agu_seq
    import agu_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_in,
    input  op_info_t           info,
    input  logic [ADDR_W-1:0]  ea_in,
    output logic [BYTE_W-1:0]  opc_view,
    output logic [BYTE_W-1:0]  disp_view,
    output logic               sel_view,
    output logic               done,
    output logic               sel_iy,
    output logic [CLS_W-1:0]   cls,
    output logic [2:0]         reg_code,
    output logic [ADDR_W-1:0]  ea,
    output logic [ADDR_W-1:0]  imm_word,
    output logic [CYC_W-1:0]   cycles,
    output logic [ADV_W-1:0]   pc_adv
);

    seq_state_t         st_q, st_d;
    logic               sel_q;
    logic [BYTE_W-1:0]  opc_q;
    logic [BYTE_W-1:0]  disp_q;
    logic [BYTE_W-1:0]  lo_q;
    logic               is_pfx;
    logic               fin;

    assign is_pfx    = (byte_in == PFX_FIRST) || (byte_in == PFX_SECOND);
    assign opc_view  = (st_q == ST_OPCODE) ? byte_in : opc_q;
    assign disp_view = (st_q == ST_DISP) ? byte_in : disp_q;
    assign sel_view  = sel_q;

    // next-state selection
    always_comb begin
        st_d = st_q;
        fin  = 1'b0;
        if (byte_vld) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (is_pfx) st_d = ST_OPCODE;             // arm
                end
                ST_OPCODE: begin
                    if (is_pfx) begin
                        st_d = ST_OPCODE;                     // rearm
                    end else if (info.need_disp) begin
                        st_d = ST_DISP;                       // to-disp
                    end else if (info.need_word) begin
                        st_d = ST_WLO;                        // to-word
                    end else begin
                        st_d = ST_IDLE;                       // finish-short
                        fin  = 1'b1;
                    end
                end
                ST_DISP: begin
                    if (info.need_imm8) begin
                        st_d = ST_IMM8;                       // to-imm
                    end else begin
                        st_d = ST_IDLE;                       // finish-disp
                        fin  = 1'b1;
                    end
                end
                ST_IMM8: begin
                    st_d = ST_IDLE;                           // finish-imm
                    fin  = 1'b1;
                end
                ST_WLO: begin
                    st_d = ST_WHI;                            // word-lo
                end
                ST_WHI: begin
                    st_d = ST_IDLE;                           // finish-word
                    fin  = 1'b1;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // operand latches and result outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            opc_q    <= '0;
            disp_q   <= '0;
            lo_q     <= '0;
            done     <= 1'b0;
            sel_iy   <= 1'b0;
            cls      <= '0;
            reg_code <= '0;
            ea       <= '0;
            imm_word <= '0;
            cycles   <= '0;
            pc_adv   <= '0;
        end else begin
            done <= fin;
            if (byte_vld) begin
                if ((st_q == ST_IDLE || st_q == ST_OPCODE) && is_pfx)
                    sel_q <= (byte_in == PFX_SECOND);
                if (st_q == ST_OPCODE && !is_pfx) opc_q <= byte_in;
                if (st_q == ST_DISP)              disp_q <= byte_in;
                if (st_q == ST_WLO)               lo_q <= byte_in;
            end
            if (fin) begin
                sel_iy   <= sel_q;
                cls      <= info.cls;
                reg_code <= info.rcode;
                cycles   <= info.cyc;
                pc_adv   <= info.adv;
                ea       <= info.need_disp ? ea_in : '0;
                if (st_q == ST_IMM8)     imm_word <= {{(ADDR_W-BYTE_W){1'b0}}, byte_in};
                else if (st_q == ST_WHI) imm_word <= {byte_in, lo_q};
                else                     imm_word <= '0;
            end
        end
    end

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(st_q));

    // R2
    idle_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && byte_vld && byte_in != PFX_FIRST && byte_in != PFX_SECOND)
        |=> (st_q == ST_IDLE && !done));

    // R11
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPCODE && byte_vld && byte_in == PFX_SECOND)
        |=> (st_q == ST_OPCODE && sel_q));

    // R13
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st_q == ST_IDLE || st_q == ST_OPCODE));

endmodule

// File: rtl/idx_prefix_agu.sv
module idx_prefix_agu
    import agu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    input  logic [15:0] ix_val,
    input  logic [15:0] iy_val,
    output logic        done,
    output logic        sel_iy,
    output logic [3:0]  cls,
    output logic [2:0]  reg_code,
    output logic [15:0] ea,
    output logic [15:0] imm_word,
    output logic [4:0]  cycles,
    output logic [2:0]  pc_adv
);

    op_info_t            info;
    logic [BYTE_W-1:0]   opc_view;
    logic [BYTE_W-1:0]   disp_view;
    logic                sel_view;
    logic [ADDR_W-1:0]   ea_calc;

    agu_opdec u_dec (
        .opc  (opc_view),
        .info (info)
    );

    agu_ea #(.AW(ADDR_W), .DW(BYTE_W)) u_ea (
        .idx_a  (ix_val),
        .idx_b  (iy_val),
        .pick_b (sel_view),
        .disp   (disp_view),
        .addr   (ea_calc)
    );

    agu_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .info      (info),
        .ea_in     (ea_calc),
        .opc_view  (opc_view),
        .disp_view (disp_view),
        .sel_view  (sel_view),
        .done      (done),
        .sel_iy    (sel_iy),
        .cls       (cls),
        .reg_code  (reg_code),
        .ea        (ea),
        .imm_word  (imm_word),
        .cycles    (cycles),
        .pc_adv    (pc_adv)
    );

    // R4
    cycle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles == 5'd8 || cycles == 5'd14 || cycles == 5'd15 || cycles == 5'd19));

    // R10
    unsup_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cls == 4'd8) |-> (pc_adv == 3'd2 && ea == 16'h0 && imm_word == 16'h0));

    // R13
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(ea) && $stable(cls)) || done);

endmodule

// File: tb/sim_idx_prefix_agu.sv
module sim_idx_prefix_agu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        byte_vld;
    logic [7:0]  byte_in;
    logic [15:0] ix_val;
    logic [15:0] iy_val;
    logic        done;
    logic        sel_iy;
    logic [3:0]  cls;
    logic [2:0]  reg_code;
    logic [15:0] ea;
    logic [15:0] imm_word;
    logic [4:0]  cycles;
    logic [2:0]  pc_adv;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    idx_prefix_agu u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .ix_val(ix_val), .iy_val(iy_val), .done(done), .sel_iy(sel_iy),
        .cls(cls), .reg_code(reg_code), .ea(ea), .imm_word(imm_word),
        .cycles(cycles), .pc_adv(pc_adv)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expectations written from the requirement list
    task automatic expect_of(input bit use_b, input logic [7:0] opc,
                             input logic [7:0] b1, input logic [7:0] b2,
                             output int e_cls, output int e_cyc, output int e_adv,
                             output int e_reg, output int e_ea, output int e_imm,
                             output int n_after);
        logic [15:0] base;
        logic [15:0] sum;
        bit          dform;
        base  = use_b ? iy_val : ix_val;
        sum   = base + {{8{b1[7]}}, b1};
        dform = 1'b0;
        e_reg = 0; e_imm = 0; e_ea = 0;
        case (opc)
            8'h46, 8'h4E, 8'h56, 8'h5E, 8'h66, 8'h6E, 8'h7E: begin
                e_cls = 1; e_cyc = 19; e_adv = 3; e_reg = int'(opc[5:3]); dform = 1; n_after = 1;
            end
            8'h70, 8'h71, 8'h72, 8'h73, 8'h74, 8'h75, 8'h77: begin
                e_cls = 2; e_cyc = 19; e_adv = 3; e_reg = int'(opc[2:0]); dform = 1; n_after = 1;
            end
            8'h36: begin
                e_cls = 3; e_cyc = 19; e_adv = 4; e_imm = int'(b2); dform = 1; n_after = 2;
            end
            8'h21: begin
                e_cls = 4; e_cyc = 14; e_adv = 4; e_imm = int'({b2, b1}); n_after = 2;
            end
            8'hE5: begin e_cls = 5; e_cyc = 15; e_adv = 2; n_after = 0; end
            8'hE1: begin e_cls = 6; e_cyc = 14; e_adv = 2; n_after = 0; end
            8'hB6: begin
                e_cls = 7; e_cyc = 19; e_adv = 3; dform = 1; n_after = 1;
            end
            default: begin e_cls = 8; e_cyc = 8; e_adv = 2; n_after = 0; end
        endcase
        if (dform) e_ea = int'(sum);
    endtask

    task automatic send(input logic [7:0] b);
        byte_vld = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_vld = 1'b0;
        byte_in  = 8'($urandom);
    endtask

    task automatic gap(input bit en);
        if (en) begin
            int n;
            n = int'($urandom % 3);
            for (int k = 0; k < n; k++) begin
                byte_in = 8'($urandom);
                @(negedge clk);
                chk("R12 no done during idle gap", int'(done), 0);
            end
        end
    endtask

    task automatic run(input logic [7:0] pfx, input logic [7:0] opc,
                       input logic [7:0] b1, input logic [7:0] b2, input bit gaps);
        int e_cls, e_cyc, e_adv, e_reg, e_ea, e_imm, n_after;
        expect_of(pfx == 8'hFD, opc, b1, b2, e_cls, e_cyc, e_adv, e_reg, e_ea, e_imm, n_after);
        send(pfx);
        gap(gaps);
        send(opc);
        if (n_after > 0) begin
            chk("R13 done low mid-instruction", int'(done), 0);
            gap(gaps);
            send(b1);
        end
        if (n_after > 1) begin
            chk("R13 done low mid-instruction", int'(done), 0);
            gap(gaps);
            send(b2);
        end
        chk("R13 done strobe", int'(done), 1);
        chk("R2 index select", int'(sel_iy), int'(pfx == 8'hFD));
        chk("R4-class code (R5 R6 R7 R8 R9 R10)", int'(cls), e_cls);
        chk("R4 cycles", int'(cycles), e_cyc);
        chk("R5 pc advance", int'(pc_adv), e_adv);
        chk("R13 reg field", int'(reg_code), e_reg);
        chk("R3 effective address", int'(ea), e_ea);
        chk("R6 immediate", int'(imm_word), e_imm);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd4711));
        rst_n    = 1'b0;
        byte_vld = 1'b0;
        byte_in  = 8'h00;
        ix_val   = 16'h1000;
        iy_val   = 16'h2000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", int'(done), 0);
        chk("R1 ea", int'(ea), 0);
        chk("R1 cls", int'(cls), 0);
        chk("R1 cycles", int'(cycles), 0);

        // R2 non-prefix bytes while idle are ignored
        send(8'h46); send(8'h05); send(8'h21);
        @(negedge clk);
        chk("R2 ignored idle bytes", int'(done), 0);
        chk("R2 ignored idle bytes cls", int'(cls), 0);
        // a following displacement load must still decode from a fresh prefix
        run(8'hDD, 8'h7E, 8'h04, 8'h00, 1'b0);

        // R3 wrap below zero and above top
        ix_val = 16'h0010;
        run(8'hDD, 8'h46, 8'h80, 8'h00, 1'b0);
        iy_val = 16'hFFF0;
        run(8'hFD, 8'h70, 8'h20, 8'h00, 1'b0);

        // R11 last prefix wins
        ix_val = 16'h1234; iy_val = 16'h5678;
        send(8'hDD); send(8'hFD);
        run(8'hFD, 8'h5E, 8'h01, 8'h00, 1'b1);
        send(8'hFD); @(negedge clk); send(8'hDD);
        run(8'hDD, 8'h66, 8'hFF, 8'h00, 1'b1);

        // R6 R7 R8 R9 R10 directed
        run(8'hDD, 8'h36, 8'h7F, 8'hA5, 1'b1);
        run(8'hFD, 8'h21, 8'h34, 8'h12, 1'b1);
        run(8'hDD, 8'hE5, 8'h00, 8'h00, 1'b0);
        run(8'hFD, 8'hE1, 8'h00, 8'h00, 1'b0);
        run(8'hDD, 8'hB6, 8'hFE, 8'h00, 1'b0);
        run(8'hDD, 8'h76, 8'h00, 8'h00, 1'b0);

        // R13 outputs hold after the strobe
        begin
            int hold_ea;
            hold_ea = int'(ea);
            @(negedge clk);
            chk("R13 done pulse ends", int'(done), 0);
            chk("R13 ea holds", int'(ea), hold_ea);
        end

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] opc;
            logic [7:0] pfx;
            ix_val = 16'($urandom);
            iy_val = 16'($urandom);
            pfx = ($urandom % 2) ? 8'hFD : 8'hDD;
            case ($urandom % 8)
                0: opc = {2'b01, 3'($urandom % 7), 3'b110};
                1: opc = 8'h70 + 8'($urandom % 6);
                2: opc = 8'h36;
                3: opc = 8'h21;
                4: opc = ($urandom % 2) ? 8'hE5 : 8'hE1;
                5: opc = 8'hB6;
                6: opc = 8'h77;
                default: opc = 8'($urandom);
            endcase
            if (opc == 8'hDD || opc == 8'hFD) opc = 8'h00;
            if (opc == 8'h76) opc = 8'h7E;
            run(pfx, opc, 8'($urandom), 8'($urandom), 1'b1);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule